// File: doc/BRIEF.md
# Edge-Line Vertex Scheduler

This block sits in front of a graph update pipeline whose edges are stored in compressed sparse row order. An internal line counter walks the edge array one line of `LANES` edges at a time. Vertices arrive in graph order on a valid/ready input. Each vertex carries its first edge index (`left`) and an exclusive end index (`right`), so it owns edges `left .. right-1`. Accepted vertices are dealt round-robin into `NUM_UNITS` small vertex units, each of which is a FIFO. In every cycle the heads of the units are examined in graph order against the current line.

A vertex is scheduled in a cycle when it owns at least one edge of the current line. It is removed from its unit once the line covers its last edge. The line moves on only when the line's edges have all been handed out. Low-degree vertices therefore share a line, and a high-degree vertex is scheduled on every line it spans. When a line holds more vertices than there are units, the same line is kept for extra cycles. Each scheduled vertex leaves with the lane of its last edge inside the line, so a downstream merger can pick the matching partial result. The run ends when the vertex holding the last edge of the graph has been retired.

Top module: `edge_line_sched`

## Requirements
- R1: After reset, `running` and `done` are low, `lineIdx` is 0, `inRdy` is high and no `schedValid` bit is set.
- R2: A `start` pulse sets `running` and returns `lineIdx` to 0 on the next clock edge, whatever line a previous run stopped on.
- R3: While running, the slots are ordered so that slot 0 holds the oldest pending vertex. A slot's `schedValid` bit is high exactly when that vertex owns at least one edge in line `lineIdx`, which covers edges `lineIdx*LANES .. lineIdx*LANES+LANES-1`. `schedId` carries that vertex's id.
- R4: For a scheduled vertex whose edges end inside the line, `schedLane` equals `(right-1) mod LANES` and `schedCont` is 0. For a vertex whose edges run past the line end, `schedLane` is `LANES-1` and `schedCont` is 1.
- R5: A vertex flagged as continuing is not retired. It appears again, in slot 0, on the next line, and it is retired on the line holding its last edge.
- R6: A vertex with `left == right` is retired without its slot's `schedValid` bit being set.
- R7: When all vertices owning edges of a line fit in one cycle, `lineIdx` advances by exactly one on the next edge.
- R8: When a line holds edges of more vertices than `NUM_UNITS`, `lineIdx` is held. The vertices left over are scheduled in the following cycle, starting at slot 0.
- R9: If the next vertex a line needs has not yet been pushed, `lineIdx` is held with no slot valid until it arrives. It is scheduled in the cycle after it is accepted.
- R10: Retiring a vertex whose `right` is at least `edgeTotal` ends the run. On the next edge `done` is high for exactly one cycle, `running` falls, and no slot is valid afterwards.
- R11: `inRdy` is low when the unit due to receive the next vertex already holds `UNIT_DEPTH` vertices. While it is low, `inVld` is ignored and no vertex is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a walk from line 0 |
| edgeTotal | input | EA_W | Number of edges in the graph |
| inVld | input | 1 | Vertex offered |
| inRdy | output | 1 | Vertex accepted when high with inVld |
| inId | input | ID_W | Vertex id |
| inLeft | input | EA_W | First edge index of the vertex |
| inRight | input | EA_W | One past the last edge index |
| running | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse after the last edge is retired |
| lineIdx | output | EA_W-log2(LANES) | Index of the line being processed |
| schedValid | output | NUM_UNITS | Per-slot scheduled flag |
| schedId | output | NUM_UNITS x ID_W | Per-slot vertex id |
| schedLane | output | NUM_UNITS x log2(LANES) | Lane of the vertex's last edge in this line |
| schedCont | output | NUM_UNITS | Vertex continues on the next line |

## Verification
The schedule outputs are combinational from registered state: unit heads, base pointer and line counter. They therefore describe the line shown on `lineIdx` in the same cycle. A vertex accepted at an edge can be scheduled from that edge onward. A line advance or hold shows one edge after the cycle that decided it, and `done` rises one edge after the retiring cycle. The bench drives and samples at the falling edge, so each sample after one clock step reads the result of exactly one decision. The expected slot contents are worked out by hand for each line from the vertex offsets.

// File: rtl/edge_line_sched_pkg.sv
package edge_line_sched_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
  } ctrl_strb_t;

  // status from datapath back to control
  typedef struct packed {
    logic lineDone;
    logic finish;
  } dp_stat_t;

endpackage

// File: rtl/vtx_unit_fifo.sv
module vtx_unit_fifo #(
  parameter int ID_W  = 16,
  parameter int EA_W  = 16,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [ID_W-1:0] pushId,
  input  logic [EA_W-1:0] pushLeft,
  input  logic [EA_W-1:0] pushRight,
  input  logic            pop,
  output logic            full,
  output logic            headVld,
  output logic [ID_W-1:0] headId,
  output logic [EA_W-1:0] headLeft,
  output logic [EA_W-1:0] headRight
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ID_W-1:0]  idMem    [DEPTH];
  logic [EA_W-1:0]  leftMem  [DEPTH];
  logic [EA_W-1:0]  rightMem [DEPTH];
  logic [PTR_W-1:0] wrP, rdP;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      idMem[wrP]    <= pushId;
      leftMem[wrP]  <= pushLeft;
      rightMem[wrP] <= pushRight;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrP <= '0;
      rdP <= '0;
      cnt <= '0;
    end else begin
      if (push) wrP <= nextPtr(wrP);
      if (pop)  rdP <= nextPtr(rdP);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign full      = (cnt == CNT_W'(DEPTH));
  assign headVld   = (cnt != '0);
  assign headId    = idMem[rdP];
  assign headLeft  = leftMem[rdP];
  assign headRight = rightMem[rdP];

endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import edge_line_sched_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  dp_stat_t          stat,
  output ctrl_strb_t        strb,
  output logic [LINE_W-1:0] lineIdx,
  output logic              running,
  output logic              done
);
  logic runQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      runQ    <= 1'b0;
      lineIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        runQ    <= 1'b1;
        lineIdx <= '0;
      end else if (runQ) begin
        if (stat.finish) begin
          runQ <= 1'b0;
          done <= 1'b1;
        end else if (stat.lineDone) begin
          lineIdx <= lineIdx + 1'b1;
        end
      end
    end
  end

  assign strb.run = runQ;
  assign running  = runQ;

endmodule

// File: rtl/sched_dp.sv
module sched_dp
  import edge_line_sched_pkg::*;
#(
  parameter int U      = 8,
  parameter int LANES  = 16,
  parameter int ID_W   = 16,
  parameter int EA_W   = 16,
  parameter int DEPTH  = 4,
  parameter int LANE_W = $clog2(LANES),
  parameter int LINE_W = EA_W - $clog2(LANES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  ctrl_strb_t                   strb,
  input  logic [LINE_W-1:0]            lineIdx,
  input  logic [EA_W-1:0]              edgeTotal,
  input  logic                         inVld,
  output logic                         inRdy,
  input  logic [ID_W-1:0]              inId,
  input  logic [EA_W-1:0]              inLeft,
  input  logic [EA_W-1:0]              inRight,
  output dp_stat_t                     stat,
  output logic [U-1:0]                 schedValid,
  output logic [U-1:0][ID_W-1:0]       schedId,
  output logic [U-1:0][LANE_W-1:0]     schedLane,
  output logic [U-1:0]                 schedCont
);
  localparam int U_W  = (U > 1) ? $clog2(U) : 1;
  localparam int WA_W = EA_W + 1;

  logic [U_W-1:0]  wrPtr, rdBase;
  logic [U-1:0]    fullVec, headVldVec, popUnit;
  logic [ID_W-1:0] headIdArr    [U];
  logic [EA_W-1:0] headLeftArr  [U];
  logic [EA_W-1:0] headRightArr [U];
  logic [U_W:0]    popCount;
  logic            accept;

  assign inRdy  = !fullVec[wrPtr];
  assign accept = inVld && inRdy;

  for (genvar u = 0; u < U; u++) begin : g_unit
    vtx_unit_fifo #(.ID_W(ID_W), .EA_W(EA_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (accept && (wrPtr == U_W'(u))),
      .pushId   (inId),
      .pushLeft (inLeft),
      .pushRight(inRight),
      .pop      (popUnit[u]),
      .full     (fullVec[u]),
      .headVld  (headVldVec[u]),
      .headId   (headIdArr[u]),
      .headLeft (headLeftArr[u]),
      .headRight(headRightArr[u])
    );
  end

  // line window, one bit wider so the end never wraps
  logic [WA_W-1:0] lineStart, lineEnd, totalW;
  assign lineStart = {1'b0, lineIdx, {LANE_W{1'b0}}};
  assign lineEnd   = lineStart + WA_W'(LANES);
  assign totalW    = {1'b0, edgeTotal};

  always_comb begin
    logic            chain;
    logic [U_W-1:0]  idx;
    logic [WA_W-1:0] l, r, rLast;
    logic            active, inLine, popS, sch, cont, last;
    schedValid = '0;
    schedId    = '0;
    schedLane  = '0;
    schedCont  = '0;
    popUnit    = '0;
    popCount   = '0;
    stat       = '0;
    chain      = strb.run;
    for (int i = 0; i < U; i++) begin
      idx    = rdBase + U_W'(i);
      l      = {1'b0, headLeftArr[idx]};
      r      = {1'b0, headRightArr[idx]};
      rLast  = r - WA_W'(1);
      active = chain && headVldVec[idx];
      inLine = (l < lineEnd);
      popS   = active && inLine && (r <= lineEnd);
      sch    = active && inLine && (l < r);
      cont   = sch && (r > lineEnd);
      last   = popS && (r >= totalW);
      if (sch) begin
        schedValid[i] = 1'b1;
        schedId[i]    = headIdArr[idx];
        schedLane[i]  = cont ? {LANE_W{1'b1}} : rLast[LANE_W-1:0];
        schedCont[i]  = cont;
      end
      if (active && (!inLine || (r > lineEnd))) stat.lineDone = 1'b1;
      if (popS && (r == lineEnd))               stat.lineDone = 1'b1;
      if (last)                                 stat.finish   = 1'b1;
      if (popS) begin
        popUnit[idx] = 1'b1;
        popCount     = popCount + 1'b1;
      end
      chain = popS && !last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr  <= '0;
      rdBase <= '0;
    end else begin
      if (accept) wrPtr <= wrPtr + 1'b1;
      rdBase <= rdBase + popCount[U_W-1:0];
    end
  end

endmodule

// File: rtl/edge_line_sched.sv
module edge_line_sched
  import edge_line_sched_pkg::*;
#(
  parameter int NUM_UNITS  = 8,
  parameter int LANES      = 16,
  parameter int ID_W       = 16,
  parameter int EA_W       = 16,
  parameter int UNIT_DEPTH = 4,
  localparam int LANE_W    = $clog2(LANES),
  localparam int LINE_W    = EA_W - LANE_W
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic [EA_W-1:0]                      edgeTotal,
  input  logic                                 inVld,
  output logic                                 inRdy,
  input  logic [ID_W-1:0]                      inId,
  input  logic [EA_W-1:0]                      inLeft,
  input  logic [EA_W-1:0]                      inRight,
  output logic                                 running,
  output logic                                 done,
  output logic [LINE_W-1:0]                    lineIdx,
  output logic [NUM_UNITS-1:0]                 schedValid,
  output logic [NUM_UNITS-1:0][ID_W-1:0]       schedId,
  output logic [NUM_UNITS-1:0][LANE_W-1:0]     schedLane,
  output logic [NUM_UNITS-1:0]                 schedCont
);
  ctrl_strb_t strb;
  dp_stat_t   stat;

  sched_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .stat   (stat),
    .strb   (strb),
    .lineIdx(lineIdx),
    .running(running),
    .done   (done)
  );

  sched_dp #(
    .U(NUM_UNITS), .LANES(LANES), .ID_W(ID_W), .EA_W(EA_W),
    .DEPTH(UNIT_DEPTH), .LANE_W(LANE_W), .LINE_W(LINE_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .lineIdx   (lineIdx),
    .edgeTotal (edgeTotal),
    .inVld     (inVld),
    .inRdy     (inRdy),
    .inId      (inId),
    .inLeft    (inLeft),
    .inRight   (inRight),
    .stat      (stat),
    .schedValid(schedValid),
    .schedId   (schedId),
    .schedLane (schedLane),
    .schedCont (schedCont)
  );

endmodule

// File: rtl/edge_line_sched_chk.sv
module edge_line_sched_chk #(
  parameter int U      = 8,
  parameter int LANE_W = 4,
  parameter int LINE_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     running,
  input logic                     done,
  input logic [LINE_W-1:0]        lineIdx,
  input logic [U-1:0]             schedValid,
  input logic [U-1:0][LANE_W-1:0] schedLane,
  input logic [U-1:0]             schedCont
);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !running);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (schedValid == '0));

  // R2
  start_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && (lineIdx == '0)));

  // R7
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start) |=>
      ((lineIdx == $past(lineIdx)) || (lineIdx == LINE_W'($past(lineIdx) + 1'b1))));

  // R5
  cont_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(schedCont) <= 1);

  for (genvar i = 0; i < U; i++) begin : g_lane
    // R4
    cont_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      schedCont[i] |-> (schedValid[i] && (schedLane[i] == '1)));
  end

endmodule

bind edge_line_sched edge_line_sched_chk #(
  .U(NUM_UNITS), .LANE_W(LANE_W), .LINE_W(LINE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .running   (running),
  .done      (done),
  .lineIdx   (lineIdx),
  .schedValid(schedValid),
  .schedLane (schedLane),
  .schedCont (schedCont)
);

// File: tb/edge_line_sched_bench.sv
module edge_line_sched_bench;
  localparam int U    = 8;
  localparam int ID_W = 16;
  localparam int EA_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [EA_W-1:0] edgeTotal = '0;
  logic inVld = 1'b0;
  logic inRdy;
  logic [ID_W-1:0] inId = '0;
  logic [EA_W-1:0] inLeft = '0, inRight = '0;
  logic running, done;
  logic [11:0] lineIdx;
  logic [U-1:0] schedValid, schedCont;
  logic [U-1:0][ID_W-1:0] schedId;
  logic [U-1:0][3:0] schedLane;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  edge_line_sched u_edge_line_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .edgeTotal(edgeTotal),
    .inVld(inVld), .inRdy(inRdy), .inId(inId), .inLeft(inLeft), .inRight(inRight),
    .running(running), .done(done), .lineIdx(lineIdx),
    .schedValid(schedValid), .schedId(schedId), .schedLane(schedLane),
    .schedCont(schedCont)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input string what, input longint act, input longint exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic chkSlot(input string req, input int s, input int id, input int lane, input bit cont);
    chkEq(req, $sformatf("slot%0d valid", s), schedValid[s], 1);
    chkEq(req, $sformatf("slot%0d id", s), schedId[s], id);
    chkEq(req, $sformatf("slot%0d lane", s), schedLane[s], lane);
    chkEq(req, $sformatf("slot%0d cont", s), schedCont[s], cont);
  endtask

  task automatic pushV(input int id, input int l, input int r);
    inVld = 1'b1; inId = ID_W'(id); inLeft = EA_W'(l); inRight = EA_W'(r);
    @(negedge clk);
    inVld = 1'b0;
  endtask

  task automatic startRun(input int total);
    edgeTotal = EA_W'(total);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expectDone(input string req);
    @(negedge clk);
    chkEq(req, "done", done, 1);
    chkEq(req, "running", running, 0);
    chkEq(req, "valid after end", schedValid, 0);
    @(negedge clk);
    chkEq(req, "done one cycle", done, 0);
  endtask

  task automatic testReset;
    chkEq("R1", "running", running, 0);
    chkEq("R1", "done", done, 0);
    chkEq("R1", "lineIdx", lineIdx, 0);
    chkEq("R1", "inRdy", inRdy, 1);
    chkEq("R1", "schedValid", schedValid, 0);
  endtask

  // mixed degrees: two short vertices, a long one over two lines, a tail
  task automatic testMixed;
    pushV(10, 0, 3); pushV(11, 3, 8); pushV(12, 8, 28); pushV(13, 28, 32);
    startRun(32);
    chkEq("R3", "mask line0", schedValid, 8'b0000_0111);
    chkEq("R2", "lineIdx start", lineIdx, 0);
    chkSlot("R4", 0, 10, 2, 0);
    chkSlot("R4", 1, 11, 7, 0);
    chkSlot("R4", 2, 12, 15, 1);
    @(negedge clk);
    chkEq("R7", "lineIdx advance", lineIdx, 1);
    chkEq("R5", "mask line1", schedValid, 8'b0000_0011);
    chkSlot("R5", 0, 12, 11, 0);
    chkSlot("R4", 1, 13, 15, 0);
    expectDone("R10");
  endtask

  // ten one-edge vertices with a zero-degree one inside: overflow of the units
  task automatic testCrowded;
    for (int k = 0; k < 10; k++) begin
      int l = (k <= 3) ? k : k - 1;
      int r = (k == 3) ? 3 : l + 1;
      pushV(30 + k, l, r);
    end
    startRun(9);
    chkEq("R6", "mask with zero-degree", schedValid, 8'b1111_0111);
    chkSlot("R3", 0, 30, 0, 0);
    chkSlot("R6", 4, 34, 3, 0);
    chkSlot("R3", 7, 37, 6, 0);
    @(negedge clk);
    chkEq("R8", "lineIdx held", lineIdx, 0);
    chkEq("R8", "mask rest", schedValid, 8'b0000_0011);
    chkSlot("R8", 0, 38, 7, 0);
    chkSlot("R8", 1, 39, 8, 0);
    expectDone("R10");
  endtask

  // one long vertex, then the walk waits for the next vertex
  task automatic testStall;
    pushV(20, 0, 40);
    startRun(48);
    chkEq("R2", "restart line", lineIdx, 0);
    chkSlot("R5", 0, 20, 15, 1);
    @(negedge clk);
    chkEq("R5", "line1", lineIdx, 1);
    chkSlot("R5", 0, 20, 15, 1);
    @(negedge clk);
    chkEq("R5", "line2", lineIdx, 2);
    chkEq("R5", "mask line2", schedValid, 8'b0000_0001);
    chkSlot("R5", 0, 20, 7, 0);
    @(negedge clk);
    chkEq("R9", "lineIdx held empty", lineIdx, 2);
    chkEq("R9", "no slot while empty", schedValid, 0);
    chkEq("R9", "still running", running, 1);
    pushV(21, 40, 48);
    chkEq("R9", "lineIdx after arrival", lineIdx, 2);
    chkSlot("R9", 0, 21, 15, 0);
    expectDone("R10");
  endtask

  // fill every unit, push once more while full, then drain
  task automatic testFull;
    for (int k = 0; k < 32; k++) begin
      if (k == 0 || k == 31) chkEq("R11", "ready before fill", inRdy, 1);
      pushV(100 + k, k, k + 1);
    end
    chkEq("R11", "ready when full", inRdy, 0);
    pushV(99, 32, 33);
    startRun(32);
    chkEq("R11", "mask c1", schedValid, 8'hff);
    chkSlot("R11", 0, 100, 0, 0);
    chkSlot("R3", 7, 107, 7, 0);
    @(negedge clk);
    chkEq("R8", "line0 held", lineIdx, 0);
    chkSlot("R3", 0, 108, 8, 0);
    chkSlot("R4", 7, 115, 15, 0);
    @(negedge clk);
    chkEq("R7", "line1", lineIdx, 1);
    chkSlot("R3", 0, 116, 0, 0);
    @(negedge clk);
    chkEq("R7", "line1 rest", lineIdx, 1);
    chkSlot("R11", 7, 131, 15, 0);
    expectDone("R10");
    chkEq("R11", "ready after drain", inRdy, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset;
    testMixed;
    testCrowded;
    testStall;
    testFull;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule